// File: doc/BRIEF.md
# Windowed ADC Engine Register Bank

This block is the software-visible register file of one converter engine. A host reaches it over a plain 32-bit register bus. Each cycle the host can issue a write strobe with address and data, or a read strobe. Read data is registered and appears one cycle after the strobe. The engine decodes a 256-byte window and has one interrupt output.

No real converter sits behind the bank. Each packed data word holds two 10-bit channel samples: the even channel in bits 9:0 and the odd channel in bits 25:16. Reading a data word returns its stored value and then advances both samples by fixed steps, which gives software a moving signal to poll. One cycle later a small sequencer compares both advanced samples against their own bounds registers. If either sample is outside its window, the sequencer latches the pair's bit in the interrupt-control register.

The sequencer has two states. SEQ_IDLE moves to SEQ_CHECK on a data-word read. SEQ_CHECK returns to SEQ_IDLE when no new data read arrives, and stays in SEQ_CHECK when a new data read arrives, taking that read's pair index. The window check fires in every cycle spent in SEQ_CHECK. The channel count is a parameter (8 by default). Storage exists only for the configured channels.

Top module: `adcw_engine_regs`

## Requirements
- R1: After reset these registers read as follows, and `irq` is low:
  - control (0x00) reads 0;
  - interrupt control (0x04) reads 0;
  - the auxiliary register (0x08) reads 0x0000000F;
  - the clock register (0x0C) reads 0x0000000F.
- R2: A write to control (0x00) stores the written word with two changes: bit 8 becomes a copy of written bit 0, and bit 5 is stored as 0.
- R3: Writes are masked by register type:
  - data words (0x10 + 4·pair) and bounds (0x30 + 4·channel) keep only bits 25:16 and 9:0; in a bounds register, bits 9:0 are the lower limit and bits 25:16 the upper limit;
  - hysteresis (0x70 + 4·channel) also keeps bit 31;
  - interrupt source (0xC0) keeps bits 15:0;
  - trim (0xC4) keeps bits 3:0.
- R4: A read strobe on a valid register returns its stored value on `bus_rdata` in the following cycle. A read strobe with `bus_wr` high in the same cycle is ignored.
- R5: After a data-word read, the word's low sample advances by 5 and its high sample by 7, each modulo 1024. The next read of that word shows the advanced values.
- R6: In the cycle after a data-word read, the two advanced samples are compared against bounds of channels 2·pair and 2·pair+1. If either sample is below its lower limit or above its upper limit, bit `pair` of interrupt control (0x04) is set.
- R7: `irq` is the OR of the pair bits of interrupt control (bit p for each configured pair p). Writing 0 to a pair bit clears it. Bits above the pair bits do not drive `irq`.
- R8: In the 8-channel configuration, these registers read as 0 and ignore writes: data words for pairs 4 to 7, and bounds and hysteresis registers for channels 8 to 15. Reading them never sets an interrupt bit.
- R9: Accesses to unaligned addresses (address bits 1:0 not zero) or to unmapped offsets read as 0 and ignore writes, leaving every register unchanged.
- R10: Interrupt control, the auxiliary register and the clock register store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset within the engine window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt, OR of the latched pair bits |

## Verification
Each fault class shows up at the ports within a known number of cycles:
- A wrong advance step or wrap stays hidden until that same data word is read again, so the bench re-reads data words often. A stale sample then appears on the very next read.
- A lost or misrouted window check shows on `irq` two clock edges after the read strobe, and on the interrupt-control value at the next read of 0x04.
- A decode fault that aliases an invalid or unaligned offset onto a live register stays silent until the live register is read back. For that reason, random writes to such addresses are interleaved with reads of every valid register.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned REG_W  = 32;

    // word indices (byte offset / 4) of the register groups
    localparam logic [5:0] WRD_CTRL = 6'd0;
    localparam logic [5:0] WRD_INTC = 6'd1;
    localparam logic [5:0] WRD_AUX  = 6'd2;
    localparam logic [5:0] WRD_CLK  = 6'd3;
    localparam logic [5:0] WRD_DATA = 6'd4;   // 0x10, one per pair, 8 slots
    localparam logic [5:0] WRD_BND  = 6'd12;  // 0x30, one per channel, 16 slots
    localparam logic [5:0] WRD_HYS  = 6'd28;  // 0x70, one per channel, 16 slots
    localparam logic [5:0] WRD_ISRC = 6'd48;  // 0xC0
    localparam logic [5:0] WRD_TRIM = 6'd49;  // 0xC4
    localparam int unsigned PAIR_SLOTS = 8;
    localparam int unsigned CH_SLOTS   = 16;

    typedef enum logic [3:0] {
        RK_NONE, RK_CTRL, RK_INTC, RK_AUX, RK_CLK,
        RK_DATA, RK_BND, RK_HYS, RK_ISRC, RK_TRIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  idx;
    } reg_sel_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_CHECK = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adcw_decode.sv
module adcw_decode
    import adcw_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int unsigned NUM_PAIRS = NUM_CH / 2;

    logic [5:0] word;
    logic [5:0] rel_data, rel_bnd, rel_hys;

    assign word     = addr[7:2];
    assign rel_data = word - WRD_DATA;
    assign rel_bnd  = word - WRD_BND;
    assign rel_hys  = word - WRD_HYS;

    always_comb begin
        sel.kind = RK_NONE;
        sel.idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == WRD_CTRL)      sel.kind = RK_CTRL;
            else if (word == WRD_INTC) sel.kind = RK_INTC;
            else if (word == WRD_AUX)  sel.kind = RK_AUX;
            else if (word == WRD_CLK)  sel.kind = RK_CLK;
            else if (word == WRD_ISRC) sel.kind = RK_ISRC;
            else if (word == WRD_TRIM) sel.kind = RK_TRIM;
            else if (word >= WRD_DATA && 32'(rel_data) < PAIR_SLOTS) begin
                if (32'(rel_data) < NUM_PAIRS) begin
                    sel.kind = RK_DATA;
                    sel.idx  = rel_data[3:0];
                end
            end else if (word >= WRD_BND && 32'(rel_bnd) < CH_SLOTS) begin
                if (32'(rel_bnd) < NUM_CH) begin
                    sel.kind = RK_BND;
                    sel.idx  = rel_bnd[3:0];
                end
            end else if (word >= WRD_HYS && 32'(rel_hys) < CH_SLOTS) begin
                if (32'(rel_hys) < NUM_CH) begin
                    sel.kind = RK_HYS;
                    sel.idx  = rel_hys[3:0];
                end
            end
        end
    end
endmodule

// File: rtl/adcw_window_chk.sv
module adcw_window_chk #(
    parameter int unsigned DW = 10
) (
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] lo_lim,
    input  logic [DW-1:0] hi_lim,
    output logic          outside
);
    assign outside = (sample < lo_lim) || (sample > hi_lim);
endmodule

// File: rtl/adcw_seq_fsm.sv
module adcw_seq_fsm
    import adcw_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    output logic             check_fire,
    output logic [IDX_W-1:0] check_idx
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) idx_q <= start_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_CHECK;
            SEQ_CHECK: state_d = start ? SEQ_CHECK : SEQ_IDLE;
        endcase
    end

    always_comb begin
        check_fire = (state_q == SEQ_CHECK);
        check_idx  = idx_q;
    end

    // R6
    check_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> check_fire);

    // R6
    check_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_fire |-> $past(start));
endmodule

// File: rtl/adcw_engine_regs.sv
module adcw_engine_regs
    import adcw_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned DW      = 10,
    parameter int unsigned LO_STEP = 5,
    parameter int unsigned HI_STEP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int unsigned NUM_PAIRS = NUM_CH / 2;
    localparam int unsigned PIDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam int unsigned CIDX_W    = PIDX_W + 1;
    localparam int unsigned HI_LSB    = 16;
    localparam int unsigned ISRC_W    = 16;
    localparam int unsigned TRIM_W    = 4;
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_ACMP  = 5;
    localparam int unsigned BIT_INIT  = 8;
    localparam logic [REG_W-1:0] SAMPLE_ONES = (REG_W'(1) << DW) - REG_W'(1);
    localparam logic [REG_W-1:0] FIELD_MASK  = SAMPLE_ONES | (SAMPLE_ONES << HI_LSB);
    localparam logic [REG_W-1:0] HYS_MASK    = FIELD_MASK | (REG_W'(1) << (REG_W - 1));
    localparam logic [REG_W-1:0] AUX_RST     = 32'h0000_000F;
    localparam logic [REG_W-1:0] CLK_RST     = 32'h0000_000F;

    reg_sel_t            sel;
    logic [REG_W-1:0]    ctrl_q, intc_q, intc_d, aux_q, clk_q, ctrl_wval;
    logic [ISRC_W-1:0]   isrc_q;
    logic [TRIM_W-1:0]   trim_q;
    logic [REG_W-1:0]    data_q [NUM_PAIRS];
    logic [REG_W-1:0]    bnd_q  [NUM_CH];
    logic [REG_W-1:0]    hys_q  [NUM_CH];
    logic [REG_W-1:0]    sel_word, adv_word, chk_word, rd_mux;
    logic                rd_go, dat_rd, chk_fire;
    logic [PIDX_W-1:0]   chk_idx;
    logic [1:0]          lane_out;

    adcw_decode #(.NUM_CH(NUM_CH)) decode_i (.addr(bus_addr), .sel(sel));

    assign rd_go    = bus_rd && !bus_wr;
    assign dat_rd   = rd_go && (sel.kind == RK_DATA);
    assign sel_word = data_q[sel.idx[PIDX_W-1:0]];

    always_comb begin
        adv_word                 = '0;
        adv_word[DW-1:0]         = sel_word[DW-1:0] + DW'(LO_STEP);
        adv_word[HI_LSB +: DW]   = sel_word[HI_LSB +: DW] + DW'(HI_STEP);
    end

    adcw_seq_fsm #(.IDX_W(PIDX_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (dat_rd),
        .start_idx  (sel.idx[PIDX_W-1:0]),
        .check_fire (chk_fire),
        .check_idx  (chk_idx)
    );

    assign chk_word = data_q[chk_idx];

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [CIDX_W-1:0] bidx;
        assign bidx = {chk_idx, 1'(ln)};
        adcw_window_chk #(.DW(DW)) win_i (
            .sample  (chk_word[ln*HI_LSB +: DW]),
            .lo_lim  (bnd_q[bidx][DW-1:0]),
            .hi_lim  (bnd_q[bidx][HI_LSB +: DW]),
            .outside (lane_out[ln])
        );
    end

    always_comb begin
        ctrl_wval           = bus_wdata;
        ctrl_wval[BIT_INIT] = bus_wdata[BIT_EN];
        ctrl_wval[BIT_ACMP] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            aux_q  <= AUX_RST;
            clk_q  <= CLK_RST;
            isrc_q <= '0;
            trim_q <= '0;
        end else if (bus_wr) begin
            unique case (sel.kind)
                RK_CTRL: ctrl_q <= ctrl_wval;
                RK_AUX:  aux_q  <= bus_wdata;
                RK_CLK:  clk_q  <= bus_wdata;
                RK_ISRC: isrc_q <= bus_wdata[ISRC_W-1:0];
                RK_TRIM: trim_q <= bus_wdata[TRIM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        intc_d = intc_q;
        if (bus_wr && sel.kind == RK_INTC) intc_d = bus_wdata;
        if (chk_fire && (lane_out != 2'b00)) intc_d = intc_d | (REG_W'(1) << chk_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) intc_q <= '0;
        else        intc_q <= intc_d;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (!rst_n) data_q[p] <= '0;
            else if (bus_wr && sel.kind == RK_DATA && 32'(sel.idx) == p)
                data_q[p] <= bus_wdata & FIELD_MASK;
            else if (dat_rd && 32'(sel.idx) == p)
                data_q[p] <= adv_word;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n) begin
                bnd_q[c] <= '0;
                hys_q[c] <= '0;
            end else if (bus_wr && 32'(sel.idx) == c) begin
                if (sel.kind == RK_BND) bnd_q[c] <= bus_wdata & FIELD_MASK;
                if (sel.kind == RK_HYS) hys_q[c] <= bus_wdata & HYS_MASK;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel.kind)
            RK_CTRL: rd_mux = ctrl_q;
            RK_INTC: rd_mux = intc_q;
            RK_AUX:  rd_mux = aux_q;
            RK_CLK:  rd_mux = clk_q;
            RK_DATA: rd_mux = sel_word;
            RK_BND:  rd_mux = bnd_q[sel.idx[CIDX_W-1:0]];
            RK_HYS:  rd_mux = hys_q[sel.idx[CIDX_W-1:0]];
            RK_ISRC: rd_mux = REG_W'(isrc_q);
            RK_TRIM: rd_mux = REG_W'(trim_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_mux;
    end

    assign irq = |intc_q[NUM_PAIRS-1:0];

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.kind == RK_CTRL) |=>
            (ctrl_q[BIT_INIT] == $past(bus_wdata[BIT_EN]) && !ctrl_q[BIT_ACMP]));

    // R5
    data_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd |=> (chk_word[DW-1:0] == DW'($past(sel_word[DW-1:0]) + DW'(LO_STEP))));

    // R6
    window_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fire && lane_out != 2'b00) |=> irq);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.kind == RK_INTC && bus_wdata[NUM_PAIRS-1:0] == '0 && !chk_fire) |=> !irq);

    // R8
    dead_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && sel.kind == RK_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/adcw_engine_regs_tb.sv
module adcw_engine_regs_tb_top;
    localparam int NCH    = 8;
    localparam int NPAIRS = NCH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_reg [64];

    always #5 clk = ~clk;

    adcw_engine_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic bit is_valid(logic [7:0] a);
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return 1'b0;
        if (w <= 3) return 1'b1;
        if (w >= 4 && w < 12) return (w - 4) < NPAIRS;
        if (w >= 12 && w < 28) return (w - 12) < NCH;
        if (w >= 28 && w < 44) return (w - 28) < NCH;
        return (w == 48) || (w == 49);
    endfunction

    function automatic string tag_of(logic [7:0] a);
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return "R9";
        if (w == 0) return "R2";
        if (w <= 3) return "R10";
        if (w >= 4 && w < 12) return ((w - 4) < NPAIRS) ? "R4" : "R8";
        if (w >= 12 && w < 44) return (((w - 12) % 16) < NCH) ? "R3" : "R8";
        if (w == 48 || w == 49) return "R3";
        return "R9";
    endfunction

    function automatic logic [31:0] masked(logic [7:0] a, logic [31:0] v);
        int w = int'(a[7:2]);
        logic [31:0] r = v;
        if (w == 0) begin r[8] = v[0]; r[5] = 1'b0; return r; end
        if (w <= 3) return v;
        if (w < 28) return v & 32'h03FF_03FF;
        if (w < 44) return v & 32'h83FF_03FF;
        if (w == 48) return v & 32'h0000_FFFF;
        return v & 32'h0000_000F;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_irq(string req);
        check(req, 32'(irq), 32'(|m_reg[1][NPAIRS-1:0]));
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (is_valid(a)) m_reg[a[7:2]] = masked(a, v);
        @(negedge clk);
        check_irq("R7");
    endtask

    task automatic bus_read(logic [7:0] a, string req);
        logic [31:0] exp;
        int w = int'(a[7:2]);
        string t = (req == "") ? tag_of(a) : req;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        exp = is_valid(a) ? m_reg[w] : 32'h0;
        check(t, bus_rdata, exp);
        if (is_valid(a) && w >= 4 && w < 12) begin
            logic [9:0] lo = 10'(exp[9:0] + 10'd5);
            logic [9:0] hi = 10'(exp[25:16] + 10'd7);
            logic [31:0] b0 = m_reg[12 + 2 * (w - 4)];
            logic [31:0] b1 = m_reg[13 + 2 * (w - 4)];
            m_reg[w] = {6'b0, hi, 6'b0, lo};
            if (lo < b0[9:0] || lo > b0[25:16] || hi < b1[9:0] || hi > b1[25:16])
                m_reg[1] = m_reg[1] | (32'd1 << (w - 4));
        end
        @(negedge clk);
        check_irq((w >= 4 && w < 12) ? "R6" : "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        for (int i = 0; i < 64; i++) m_reg[i] = '0;
        m_reg[2] = 32'h0000_000F;
        m_reg[3] = 32'h0000_000F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", 32'(irq), 32'h0);
        bus_read(8'h00, "R1");
        bus_read(8'h04, "R1");
        bus_read(8'h08, "R1");
        bus_read(8'h0C, "R1");

        // R2 control side effects
        bus_write(8'h00, 32'hFFFF_0021);
        bus_read(8'h00, "R2");
        check("R2", m_reg[0], 32'hFFFF_0101);
        bus_write(8'h00, 32'h0000_0130);
        bus_read(8'h00, "R2");

        // R3 masks, R10 full-width registers
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h34, "R3");
        bus_write(8'h78, 32'hFFFF_FFFF);
        bus_read(8'h78, "R3");
        bus_write(8'hC0, 32'hFFFF_FFFF);
        bus_read(8'hC0, "R3");
        bus_write(8'hC4, 32'hFFFF_FFFF);
        bus_read(8'hC4, "R3");
        bus_write(8'h08, 32'hA5A5_5A5A);
        bus_read(8'h08, "R10");
        bus_write(8'h0C, 32'h1234_8765);
        bus_read(8'h0C, "R10");

        // R4 R5 wrap of both samples
        bus_write(8'h30, 32'h03FF_0000);
        bus_write(8'h34, 32'h03FF_0000);
        bus_write(8'h10, 32'hFFFE_FFFD);
        bus_read(8'h10, "R4");
        bus_read(8'h10, "R5");
        check("R5", m_reg[4], 32'h000C_0007);

        // R6 high sample below its lower limit, then R7 clear
        bus_write(8'h10, 32'h0000_0000);
        bus_read(8'h10, "R6");
        check("R6", 32'(irq), 32'h0);
        bus_write(8'h34, 32'h03FF_0200);
        bus_read(8'h10, "R6");
        check("R6", 32'(irq), 32'h1);
        bus_read(8'h04, "R6");
        bus_write(8'h04, 32'h0000_0000);
        check("R7", 32'(irq), 32'h0);
        bus_write(8'h04, 32'hFFFF_FFF0);
        check("R7", 32'(irq), 32'h0);
        bus_read(8'h04, "R10");
        bus_write(8'h04, 32'h0);

        // R8 invalid channel registers
        bus_write(8'h20, 32'h0123_0456);
        bus_read(8'h20, "R8");
        bus_write(8'h54, 32'h0123_0456);
        bus_read(8'h54, "R8");
        bus_write(8'h90, 32'h8123_0456);
        bus_read(8'h90, "R8");

        // R9 unaligned / unmapped
        bus_write(8'h12, 32'h03FF_03FF);
        bus_read(8'h11, "R9");
        bus_write(8'hB0, 32'hFFFF_FFFF);
        bus_read(8'hB0, "R9");
        bus_write(8'hFC, 32'hFFFF_FFFF);
        bus_read(8'hFC, "R9");
        bus_read(8'h04, "R9");

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            int          sel = int'($urandom % 10);
            logic [7:0]  a = 8'($urandom % 52) << 2;
            logic [31:0] v = $urandom;
            if (sel == 0) a = a | 8'($urandom % 3 + 1);
            if (sel >= 1 && sel <= 3) a = 8'h10 + 8'(($urandom % NPAIRS) << 2);
            if (sel == 4 && v[0]) v = 32'h03FF_0000 & $urandom | 32'h0200_0000;
            if (sel <= 5) bus_read(a, "");
            else bus_write(a, v);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule